// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller sits between a bank of interrupt request lines and a processor core. Each line has a programmable priority, where a smaller number means more urgent and level 0 is the most urgent. Each line also has an enable bit and a pending bit. The controller picks the most urgent enabled pending line. It offers that line to the core only if it beats the priority of the handler currently running. It keeps a stack of the priorities of interrupted handlers, so nesting is handled entirely in hardware.

The core raises `ack_i` to start saving its context. The controller counts a fixed number of stacking cycles. At the end of stacking it delivers the vector of whatever line is most urgent at that moment, so a request that arrives during stacking takes the place of the one that was acknowledged. When a handler exits through `done_i`, the controller checks for a pending line that beats the level underneath. If one exists, that line is entered in the next cycle without an unstack/restack sequence. Otherwise the stack pops.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Arbitration offers the enabled pending line with the numerically smallest priority on `req_vec_o`.
- R2: Among lines of equal priority, the lowest line number wins.
- R3: A pending line strictly more urgent than the active level raises `req_o`. Entering it pushes one level: `depth_o` grows by one and `act_prio_o` becomes that line's priority.
- R4: When `done_i` is given and a pending line beats the level below the active one, `ent_o` pulses in the next cycle with `ent_tail_o`=1 and that line's vector. `depth_o` is unchanged and `act_prio_o` becomes the new line's priority.
- R5: A pending line of equal or less urgent priority than the active level keeps `req_o` low.
- R6: `done_i` with no qualifying pending line pops one level. `act_prio_o` returns to the previous level, or to 2^PRIO_W (8 by default) when the stack is empty.
- R7: A line that becomes the most urgent during stacking is the vector delivered at the end of stacking. `req_o` stays low while stacking.
- R8: The pending bit is set on a rising request edge. While the line is disabled, the bit is held without raising `req_o`. Enabling the line then offers it.
- R9: A line's pending bit clears when its handler is entered.
- R10: `req_o` rises one cycle after the request edge. `ent_o` follows exactly STACK_CYC cycles after the acknowledge cycle, so with the default of 4 and an immediate acknowledge the total is no more than 12 cycles.
- R11: After reset, `req_o`=0, `ent_o`=0, `depth_o`=0 and `act_prio_o`=2^PRIO_W.
- R12: `depth_o` never exceeds 2^PRIO_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NLINES | Request lines, edge sensed |
| en_i | input | NLINES | Per-line enable |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | $clog2(NLINES) | Line whose priority is written |
| prio_dat | input | PRIO_W | Priority value written |
| ack_i | input | 1 | Core starts context stacking |
| done_i | input | 1 | Core exits the active handler |
| req_o | output | 1 | A request may preempt now |
| req_vec_o | output | $clog2(NLINES) | Line currently winning arbitration |
| ent_o | output | 1 | One-cycle handler entry pulse |
| ent_vec_o | output | $clog2(NLINES) | Line being entered |
| ent_tail_o | output | 1 | Entry came from a handler exit (no stacking) |
| act_prio_o | output | PRIO_W+1 | Active priority, 2^PRIO_W when idle |
| depth_o | output | PRIO_W+1 | Number of nested handlers |

## Verification
The hardest case to reach is late arrival. A more urgent edge must land strictly inside the stacking window, after `ack_i` has been sampled but before the final count. The stimulus reaches it by asserting the second request in the cycle right after the acknowledge and then counting the remaining stacking cycles exactly. Tail-chaining is reached by leaving two or more requests pending under an active handler and then issuing `done_i`. In that setup a lower-priority request is chained only after a higher one has finished.

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl #(
  parameter int NLINES    = 32,
  parameter int PRIO_W    = 3,
  parameter int STACK_CYC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINES-1:0]         irq_i,
  input  logic [NLINES-1:0]         en_i,
  input  logic                      prio_we,
  input  logic [$clog2(NLINES)-1:0] prio_sel,
  input  logic [PRIO_W-1:0]         prio_dat,
  input  logic                      ack_i,
  input  logic                      done_i,
  output logic                      req_o,
  output logic [$clog2(NLINES)-1:0] req_vec_o,
  output logic                      ent_o,
  output logic [$clog2(NLINES)-1:0] ent_vec_o,
  output logic                      ent_tail_o,
  output logic [PRIO_W:0]           act_prio_o,
  output logic [PRIO_W:0]           depth_o
);
  localparam int NLEV  = 1 << PRIO_W;
  localparam int IDX_W = $clog2(NLINES);
  localparam int SP_W  = PRIO_W + 1;
  localparam int CNT_W = $clog2(STACK_CYC + 1);

  logic [NLINES-1:0] irq_q, pend_q, clr_mask;
  logic [PRIO_W-1:0] prio_q [NLINES];
  logic [PRIO_W-1:0] lvl_q  [NLEV];
  logic [SP_W-1:0]   sp_q;
  logic              stk_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [SP_W-1:0]   best_p, top_p, below_p;
  logic [IDX_W-1:0]  best_i;
  logic              enter_stk, enter_tail, take;

  always_comb begin
    best_p = SP_W'(NLEV);
    best_i = '0;
    for (int i = 0; i < NLINES; i++)
      if (pend_q[i] && en_i[i] && {1'b0, prio_q[i]} < best_p) begin
        best_p = {1'b0, prio_q[i]};
        best_i = IDX_W'(i);
      end
  end

  assign top_p   = (sp_q == 0) ? SP_W'(NLEV) : {1'b0, lvl_q[PRIO_W'(sp_q - 1)]};
  assign below_p = (sp_q < 2)  ? SP_W'(NLEV) : {1'b0, lvl_q[PRIO_W'(sp_q - 2)]};

  assign enter_stk  = stk_q && cnt_q == 0 && best_p < top_p;
  assign enter_tail = !stk_q && done_i && sp_q != 0 && best_p < below_p;
  assign take       = enter_stk || enter_tail;
  assign clr_mask   = take ? (NLINES'(1) << best_i) : '0;

  assign req_o      = !stk_q && best_p < top_p;
  assign req_vec_o  = best_i;
  assign act_prio_o = top_p;
  assign depth_o    = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= '0;
      pend_q     <= '0;
      sp_q       <= '0;
      stk_q      <= 1'b0;
      cnt_q      <= '0;
      ent_o      <= 1'b0;
      ent_tail_o <= 1'b0;
      ent_vec_o  <= '0;
      for (int i = 0; i < NLINES; i++) prio_q[i] <= PRIO_W'(NLEV - 1);
      for (int j = 0; j < NLEV; j++)   lvl_q[j]  <= '0;
    end else begin
      irq_q      <= irq_i;
      pend_q     <= (pend_q & ~clr_mask) | (irq_i & ~irq_q);
      ent_o      <= 1'b0;
      ent_tail_o <= 1'b0;
      if (prio_we) prio_q[prio_sel] <= prio_dat;
      if (stk_q) begin
        if (cnt_q == 0) begin
          stk_q <= 1'b0;
          if (enter_stk) begin
            lvl_q[PRIO_W'(sp_q)] <= best_p[PRIO_W-1:0];
            sp_q      <= sp_q + 1'b1;
            ent_o     <= 1'b1;
            ent_vec_o <= best_i;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (done_i && sp_q != 0) begin
        if (enter_tail) begin
          lvl_q[PRIO_W'(sp_q - 1)] <= best_p[PRIO_W-1:0];
          ent_o      <= 1'b1;
          ent_tail_o <= 1'b1;
          ent_vec_o  <= best_i;
        end else begin
          sp_q <= sp_q - 1'b1;
        end
      end else if (ack_i && req_o) begin
        stk_q <= 1'b1;
        cnt_q <= CNT_W'(STACK_CYC - 1);
      end
    end
  end
endmodule

// File: rtl/irq_nest_chk.sv
`timescale 1ns/1ps
module irq_nest_chk #(
  parameter int NLEV      = 8,
  parameter int STACK_CYC = 4,
  parameter int SP_W      = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_o,
  input logic            ent_o,
  input logic            ent_tail_o,
  input logic            done_i,
  input logic            stacking,
  input logic [SP_W-1:0] act_prio_o,
  input logic [SP_W-1:0] depth_o
);
  int stk_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        stk_cnt <= 0;
    else if (stacking) stk_cnt <= stk_cnt + 1;
    else               stk_cnt <= 0;

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) depth_o <= SP_W'(NLEV)); // R12
  AST_NEST_DEEPER: assert property (@(posedge clk) disable iff (!rst_n) ent_o && !ent_tail_o |-> act_prio_o < $past(act_prio_o)); // R3
  AST_TAIL_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n) ent_o && ent_tail_o |-> $past(done_i)); // R4
  AST_TAIL_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n) ent_o && ent_tail_o |-> depth_o == $past(depth_o)); // R4
  AST_QUIET_STACKING: assert property (@(posedge clk) disable iff (!rst_n) stacking |-> !req_o); // R7
  AST_STACK_LEN: assert property (@(posedge clk) disable iff (!rst_n) ent_o && !ent_tail_o |-> stk_cnt == STACK_CYC); // R10
endmodule

bind irq_nest_ctrl irq_nest_chk #(.NLEV(NLEV), .STACK_CYC(STACK_CYC), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .ent_o(ent_o), .ent_tail_o(ent_tail_o),
  .done_i(done_i), .stacking(stk_q), .act_prio_o(act_prio_o), .depth_o(depth_o)
);

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/1ps
module sim_irq_nest_ctrl;
  localparam int NL = 32, PW = 3, SC = 4, IW = $clog2(NL);

  logic clk = 0, rst_n = 0;
  logic [NL-1:0] irq = '0, en = '1;
  logic prio_we = 0, ack = 0, done = 0;
  logic [IW-1:0] prio_sel = '0;
  logic [PW-1:0] prio_dat = '0;
  logic req, ent, tail;
  logic [IW-1:0] rvec, evec;
  logic [PW:0] act, depth;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_nest_ctrl #(.NLINES(NL), .PRIO_W(PW), .STACK_CYC(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .en_i(en), .prio_we(prio_we),
    .prio_sel(prio_sel), .prio_dat(prio_dat), .ack_i(ack), .done_i(done),
    .req_o(req), .req_vec_o(rvec), .ent_o(ent), .ent_vec_o(evec),
    .ent_tail_o(tail), .act_prio_o(act), .depth_o(depth));

  localparam int TBL [6][5] = '{
    '{3, 5, 7, 2, 7}, '{3, 2, 7, 2, 3}, '{10, 4, 1, 4, 1},
    '{0, 7, 31, 0, 31}, '{5, 1, 6, 0, 6}, '{20, 3, 21, 3, 20}};

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string r, int a, int e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; irq = '0; en = '1; ack = 0; done = 0; prio_we = 0;
    step(2); rst_n = 1; step(1);
  endtask

  task automatic setp(int l, int p);
    prio_we = 1; prio_sel = IW'(l); prio_dat = PW'(p); step(1); prio_we = 0;
  endtask

  task automatic pulse(logic [NL-1:0] m);
    irq = irq | m; step(1); irq = irq & ~m;
  endtask

  task automatic enter();
    ack = 1; step(1); ack = 0; step(SC);
  endtask

  task automatic finish_run();
    done = 0;
    step(1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic exit_hdl();
    done = 1; step(1); done = 0;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R11 req", req, 0); chk("R11 ent", ent, 0);
    chk("R11 depth", depth, 0); chk("R11 act", act, 8);

    for (int r = 0; r < 6; r++) begin
      do_reset();
      setp(TBL[r][0], TBL[r][1]);
      setp(TBL[r][2], TBL[r][3]);
      pulse((NL'(1) << TBL[r][0]) | (NL'(1) << TBL[r][2]));
      chk("R1/R2 req", req, 1);
      chk(TBL[r][1] == TBL[r][3] ? "R2 tie vec" : "R1 vec", rvec, TBL[r][4]);
    end

    // R3 nesting and R6 pop
    do_reset(); setp(2, 5); setp(9, 1);
    pulse(NL'(1) << 2); enter();
    chk("R3 ent", ent, 1); chk("R3 vec", evec, 2); chk("R3 act", act, 5); chk("R3 depth", depth, 1);
    step(1); pulse(NL'(1) << 9);
    chk("R3 req", req, 1); chk("R3 rvec", rvec, 9);
    enter();
    chk("R3 nested vec", evec, 9); chk("R3 nested act", act, 1); chk("R3 nested depth", depth, 2);
    step(1); exit_hdl();
    chk("R6 no ent", ent, 0); chk("R6 act", act, 5); chk("R6 depth", depth, 1);
    exit_hdl();
    chk("R6 idle act", act, 8); chk("R6 idle depth", depth, 0);

    // R5 no preempt, R4 tail chaining, R9 clear
    do_reset(); setp(4, 3); setp(5, 3); setp(6, 6);
    pulse(NL'(1) << 4); enter(); step(1);
    pulse(NL'(1) << 5); chk("R5 equal", req, 0);
    pulse(NL'(1) << 6); chk("R5 lower", req, 0);
    exit_hdl();
    chk("R4 ent", ent, 1); chk("R4 tail", tail, 1); chk("R4 vec", evec, 5);
    chk("R4 depth", depth, 1); chk("R4 act", act, 3);
    step(1); exit_hdl();
    chk("R4 second tail", tail, 1); chk("R4 second vec", evec, 6); chk("R4 act6", act, 6);
    step(1); chk("R9 cleared", req, 0);
    exit_hdl(); chk("R6 empty", depth, 0);

    // R7 late arrival
    do_reset(); setp(12, 6); setp(13, 2);
    pulse(NL'(1) << 12);
    ack = 1; step(1); ack = 0;
    irq[13] = 1; step(1); irq[13] = 0;
    chk("R7 quiet", req, 0);
    step(SC - 2); chk("R7 not yet", ent, 0);
    step(1);
    chk("R7 ent", ent, 1); chk("R7 vec", evec, 13); chk("R7 act", act, 2);
    step(1); chk("R5 under 13", req, 0);
    exit_hdl(); chk("R4 chain 12", evec, 12); chk("R4 chain tail", tail, 1);

    // R8 disabled holds pending
    do_reset(); setp(17, 0); en[17] = 0;
    pulse(NL'(1) << 17); chk("R8 masked", req, 0);
    step(3); chk("R8 still masked", req, 0);
    en[17] = 1; step(1);
    chk("R8 released", req, 1); chk("R8 vec", rvec, 17);
    enter(); chk("R8 ent vec", evec, 17);
    step(1); exit_hdl(); step(1);
    chk("R9 no repeat", req, 0);

    // R10 latency
    do_reset(); setp(8, 4);
    irq[8] = 1; step(1);
    chk("R10 req after 1", req, 1);
    ack = 1; step(1); ack = 0;
    step(SC - 1); chk("R10 early", ent, 0);
    step(1); chk("R10 ent", ent, 1);
    chk("R10 bound", (SC + 2) <= 12, 1);
    irq[8] = 0;

    finish_run();
  end
endmodule